// File: doc/BRIEF.md
# Barrel Shifter with Exponent Derivation

This block shifts a 16-bit word inside a 32-bit result field and derives block floating-point exponents, all in one clock cycle per operation. The word is placed either in the upper or in the lower half of the field, so a multiword operand can be shifted one half at a time. The shift amount is an 8-bit two's-complement value: positive values move bits toward the MSB and negative values move them toward the LSB.

Besides plain logical and arithmetic shifts, the block counts the redundant sign bits of a word (derive exponent). It shifts a word left until its first significant bit sits just below the sign bit (normalize), and it shifts a word right by a given amount (denormalize). A small tracker keeps the largest exponent derived since the last clear. An array can then be scaled by one common amount.

The tracker is a two-state machine. BLK_EMPTY reads 0 and holds no exponent yet. BLK_TRACK holds a running maximum. Its transitions are: T_FIRST (BLK_EMPTY to BLK_TRACK on the first derivation, loading that exponent), T_RAISE (BLK_TRACK to itself, taking a larger exponent), T_RESTART (clear together with a derivation: stay in BLK_TRACK and load the new exponent), and T_CLEAR (clear alone: BLK_TRACK to BLK_EMPTY).

Top module: `bshift_unit`

## Requirements
- R1: After reset, `result`, `exp_out` and `blk_exp` are 0, `out_valid` is 0, and the tracker is in BLK_EMPTY.
- R2: Op code 0 (logical shift) zero-extends a low-placed word, shifts left by `shamt` when it is non-negative and right with zero fill when it is negative. A magnitude of 32 or more gives all zeros.
- R3: Op code 1 (arithmetic shift) sign-extends a low-placed word. It shifts left like R2 and shifts right with sign fill when `shamt` is negative. A right magnitude of 32 or more gives 32 copies of the sign bit.
- R4: With `place_hi` = 1 the word occupies bits 31:16 of the field and bits 15:0 are zero, for every op code.
- R5: Op code 2 (derive exponent) sets `exp_out` to minus the count of bits below bit 15 that equal bit 15 before the first differing bit. 0x0000 and 0xFFFF give -15. `result` is left unchanged.
- R6: Op code 3 (normalize) shifts the placed field left by the count from R5 and writes the R5 exponent to `exp_out`.
- R7: Op code 4 (denormalize) shifts the placed, sign-extended field right arithmetically by the magnitude of `shamt`. The sign of `shamt` is ignored. `exp_out` is unchanged.
- R8: Results appear on the first rising edge after `in_valid` is sampled high, with `out_valid` high for that cycle. With `in_valid` low, `result` and `exp_out` hold. Op codes 5 to 7 change neither `result` nor `exp_out`.
- R9: Op codes 2 and 3 with `in_valid` feed the tracker. In BLK_EMPTY the first one loads `blk_exp`. In BLK_TRACK, `blk_exp` takes the new exponent only when it is larger.
- R10: `blk_clr` alone sends the tracker to BLK_EMPTY with `blk_exp` = 0. When `blk_clr` is high in the same cycle as a derivation, `blk_exp` loads that derivation's exponent and the tracker stays in BLK_TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 3 | Op code: 0 lsh, 1 ash, 2 exp, 3 norm, 4 denorm |
| data_in | input | 16 | Input word |
| shamt | input | 8 | Signed shift amount |
| place_hi | input | 1 | 1: word in upper half, 0: lower half |
| blk_clr | input | 1 | Restart block-exponent tracking |
| out_valid | output | 1 | Result registered from last request |
| result | output | 32 | Shifted field |
| exp_out | output | 8 | Last derived exponent, signed |
| blk_exp | output | 8 | Largest exponent since clear, signed |

## Verification
A tracker clear and an exponent derivation can fall in the same cycle. The clear can then either discard or keep the new word's exponent. The bench provokes this with directed vectors, after tracking has raised `blk_exp` to a higher value, and again at random through an independent `blk_clr` draw. It judges the outcome against a model in which the word seen with the clear starts the new block. Normalize also updates both the result and the exponent in one cycle, and every such vector compares both values.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
    typedef enum logic [2:0] {
        OP_LSH    = 3'd0,
        OP_ASH    = 3'd1,
        OP_EXP    = 3'd2,
        OP_NORM   = 3'd3,
        OP_DENORM = 3'd4
    } shop_e;

    typedef enum logic {
        BLK_EMPTY = 1'b0,
        BLK_TRACK = 1'b1
    } blk_state_e;
endpackage

// File: rtl/bshift_expdet.sv
module bshift_expdet #(
    parameter int DW = 16,
    parameter int SW = 8
) (
    input  logic [DW-1:0]         word_i,
    output logic [$clog2(DW)-1:0] cnt_o,
    output logic [SW-1:0]         exp_o
);
    localparam int CW = $clog2(DW);

    always_comb begin
        logic stop;
        cnt_o = '0;
        stop  = 1'b0;
        for (int i = DW - 2; i >= 0; i--) begin
            if (!stop) begin
                if (word_i[i] == word_i[DW-1]) cnt_o = cnt_o + CW'(1);
                else                           stop  = 1'b1;
            end
        end
        exp_o = SW'(0) - SW'(cnt_o);
    end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 8
) (
    input  logic [2:0]            op_i,
    input  logic [DW-1:0]         word_i,
    input  logic [SW-1:0]         shamt_i,
    input  logic                  hi_i,
    input  logic [$clog2(DW)-1:0] ncnt_i,
    output logic [2*DW-1:0]       res_o
);
    localparam int FW = 2 * DW;
    localparam int MW = SW + 1;

    logic [FW-1:0]        field;
    logic signed [MW-1:0] s_ext;
    logic [MW-1:0]        mag;
    logic                 neg;

    function automatic logic [FW-1:0] f_shl(input logic [FW-1:0] f, input logic [MW-1:0] a);
        return (a >= MW'(FW)) ? '0 : (f << a);
    endfunction

    function automatic logic [FW-1:0] f_shr_l(input logic [FW-1:0] f, input logic [MW-1:0] a);
        return (a >= MW'(FW)) ? '0 : (f >> a);
    endfunction

    function automatic logic [FW-1:0] f_shr_a(input logic [FW-1:0] f, input logic [MW-1:0] a);
        return (a >= MW'(FW)) ? {FW{f[FW-1]}} : $unsigned($signed(f) >>> a);
    endfunction

    always_comb begin
        if (hi_i)                 field = {word_i, {DW{1'b0}}};
        else if (op_i == OP_LSH)  field = {{DW{1'b0}}, word_i};
        else                      field = {{DW{word_i[DW-1]}}, word_i};
        neg   = shamt_i[SW-1];
        s_ext = $signed({shamt_i[SW-1], shamt_i});
        mag   = neg ? $unsigned(-s_ext) : $unsigned(s_ext);
    end

    always_comb begin
        unique case (op_i)
            OP_LSH:    res_o = neg ? f_shr_l(field, mag) : f_shl(field, mag);
            OP_ASH:    res_o = neg ? f_shr_a(field, mag) : f_shl(field, mag);
            OP_NORM:   res_o = f_shl(field, MW'(ncnt_i));
            OP_DENORM: res_o = f_shr_a(field, mag);
            default:   res_o = field;
        endcase
    end
endmodule

// File: rtl/bshift_blkexp.sv
module bshift_blkexp
    import bshift_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          derive_i,
    input  logic          clr_i,
    input  logic [SW-1:0] exp_i,
    output logic [SW-1:0] blk_o
);
    blk_state_e    state_q, state_d;
    logic [SW-1:0] blk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BLK_EMPTY;
            blk_o   <= '0;
        end else begin
            state_q <= state_d;
            blk_o   <= blk_d;
        end
    end

    always_comb begin
        state_d = state_q;
        blk_d   = blk_o;
        unique case (state_q)
            BLK_EMPTY: begin
                if (derive_i) begin
                    state_d = BLK_TRACK;
                    blk_d   = exp_i;
                end
            end
            BLK_TRACK: begin
                if (clr_i) begin
                    if (derive_i) begin
                        blk_d = exp_i;
                    end else begin
                        state_d = BLK_EMPTY;
                        blk_d   = '0;
                    end
                end else if (derive_i && ($signed(exp_i) > $signed(blk_o))) begin
                    blk_d = exp_i;
                end
            end
            default: begin
                state_d = BLK_EMPTY;
                blk_d   = '0;
            end
        endcase
    end

    AST_BLK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BLK_TRACK && !clr_i) |=> ($signed(blk_o) >= $signed($past(blk_o)))); // R9
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !derive_i) |=> (blk_o == '0)); // R10
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op_sel,
    input  logic [DW-1:0]   data_in,
    input  logic [SW-1:0]   shamt,
    input  logic            place_hi,
    input  logic            blk_clr,
    output logic            out_valid,
    output logic [2*DW-1:0] result,
    output logic [SW-1:0]   exp_out,
    output logic [SW-1:0]   blk_exp
);
    localparam int FW = 2 * DW;
    localparam int CW = $clog2(DW);

    logic [CW-1:0] ncnt;
    logic [SW-1:0] dexp;
    logic [FW-1:0] core_res;
    logic          upd_res, upd_exp, derive;

    bshift_expdet #(.DW(DW), .SW(SW)) u_expdet (
        .word_i (data_in),
        .cnt_o  (ncnt),
        .exp_o  (dexp)
    );

    bshift_core #(.DW(DW), .SW(SW)) u_core (
        .op_i    (op_sel),
        .word_i  (data_in),
        .shamt_i (shamt),
        .hi_i    (place_hi),
        .ncnt_i  (ncnt),
        .res_o   (core_res)
    );

    always_comb begin
        upd_res = (op_sel == OP_LSH) || (op_sel == OP_ASH) ||
                  (op_sel == OP_NORM) || (op_sel == OP_DENORM);
        upd_exp = (op_sel == OP_EXP) || (op_sel == OP_NORM);
        derive  = in_valid && upd_exp;
    end

    bshift_blkexp #(.SW(SW)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .derive_i (derive),
        .clr_i    (blk_clr),
        .exp_i    (dexp),
        .blk_o    (blk_exp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            exp_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && upd_res) result  <= core_res;
            if (in_valid && upd_exp) exp_out <= dexp;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(result) && $stable(exp_out))); // R8
    AST_EXP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_sel) == OP_EXP) |-> $stable(result)); // R5
    AST_NORM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_sel) == OP_NORM && $past(place_hi) &&
         $past(data_in) != '0 && $past(data_in) != '1) |-> (result[FW-1] != result[FW-2])); // R6
    AST_DENORM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_sel) == OP_DENORM) |-> (result[FW-1] == $past(data_in[DW-1]))); // R7
endmodule

// File: tb/bshift_unit_tb.sv
module bshift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [15:0] data_in = '0;
    logic [7:0]  shamt = '0;
    logic        place_hi = 1'b0;
    logic        blk_clr = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [7:0]  exp_out;
    logic [7:0]  blk_exp;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_res = '0;
    logic [7:0]  m_exp = '0;
    logic [7:0]  m_blk = '0;
    bit          m_track = 0;

    always #5 clk = ~clk;

    bshift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .data_in(data_in), .shamt(shamt), .place_hi(place_hi), .blk_clr(blk_clr),
        .out_valid(out_valid), .result(result), .exp_out(exp_out), .blk_exp(blk_exp)
    );

    function automatic int ref_cnt(input logic [15:0] d);
        int c = 0;
        for (int i = 14; i >= 0; i--) begin
            if (d[i] != d[15]) break;
            c++;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_field(input logic [15:0] d, input bit hi, input int op);
        if (hi) return {d, 16'h0000};
        if (op == 0) return {16'h0000, d};
        return {{16{d[15]}}, d};
    endfunction

    function automatic logic [31:0] ref_sh(input logic [31:0] f, input int amt, input bit left, input bit arith);
        if (left) return (amt >= 32) ? 32'h0 : (f << amt);
        if (amt >= 32) return arith ? {32{f[31]}} : 32'h0;
        return arith ? $unsigned($signed(f) >>> amt) : (f >> amt);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input int op, input logic [15:0] d, input logic [7:0] sh,
                         input bit hi, input bit v, input bit clr);
        int amt;
        int c;
        logic [7:0] e;
        logic [31:0] f;
        bit der;
        string rtag;
        @(negedge clk);
        op_sel = 3'(op); data_in = d; shamt = sh; place_hi = hi; in_valid = v; blk_clr = clr;
        amt = sh[7] ? -$signed(sh) : $signed(sh);
        c   = ref_cnt(d);
        e   = 8'(-c);
        f   = ref_field(d, hi, op);
        der = v && (op == 2 || op == 3);
        rtag = hi ? "R4" : "R2";
        if (v) begin
            case (op)
                0: m_res = ref_sh(f, amt, !sh[7], 0);
                1: begin m_res = ref_sh(f, amt, !sh[7], 1); rtag = hi ? "R4" : "R3"; end
                2: begin m_exp = e; rtag = "R5"; end
                3: begin m_res = ref_sh(f, c, 1, 0); m_exp = e; rtag = "R6"; end
                4: begin m_res = ref_sh(f, amt, 0, 1); rtag = "R7"; end
                default: rtag = "R8";
            endcase
        end else rtag = "R8";
        if (!m_track) begin
            if (der) begin m_blk = e; m_track = 1; end
        end else if (clr) begin
            if (der) m_blk = e;
            else begin m_blk = '0; m_track = 0; end
        end else if (der && $signed(e) > $signed(m_blk)) m_blk = e;
        @(negedge clk);
        chk(rtag, "result", result, m_res);
        chk((op == 3) ? "R6" : "R5", "exp_out", 32'(exp_out), 32'(m_exp));
        chk(clr ? "R10" : "R9", "blk_exp", 32'(blk_exp), 32'(m_blk));
        chk("R8", "out_valid", 32'(out_valid), 32'(v));
    endtask

    initial begin
        #(1_500_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", "result", result, 32'h0);
        chk("R1", "exp_out", 32'(exp_out), 32'h0);
        chk("R1", "blk_exp", 32'(blk_exp), 32'h0);
        chk("R1", "out_valid", 32'(out_valid), 32'h0);
        rst_n = 1'b1;

        apply(0, 16'h8001, 8'd4, 0, 1, 0);    // R2 left
        apply(0, 16'h8001, 8'hFC, 1, 1, 0);   // R2/R4 right
        apply(0, 16'hFFFF, 8'd40, 0, 1, 0);   // R2 over-range
        apply(0, 16'hFFFF, 8'h80, 1, 1, 0);   // R2 -128
        apply(1, 16'h8000, 8'hD8, 0, 1, 0);   // R3 right over-range sign
        apply(1, 16'h8000, 8'hF8, 1, 1, 0);   // R3 right
        apply(1, 16'h4001, 8'd3, 0, 1, 0);    // R3 left
        apply(2, 16'h0000, 8'd0, 0, 1, 0);    // R5 -15, tracker first
        apply(2, 16'hFFFF, 8'd0, 0, 1, 0);    // R5 -15
        apply(2, 16'h0001, 8'd0, 0, 1, 0);    // R5 -14
        apply(2, 16'h4000, 8'd0, 0, 1, 0);    // R5 0, R9 raise
        apply(3, 16'h0001, 8'd0, 1, 1, 0);    // R6 hi
        apply(3, 16'hFFF0, 8'd0, 0, 1, 0);    // R6 lo negative
        apply(4, 16'h8100, 8'd3, 1, 1, 0);    // R7
        apply(4, 16'h8100, 8'hFD, 1, 1, 0);   // R7 sign of shamt ignored
        apply(5, 16'h1234, 8'd1, 0, 1, 0);    // R8 reserved
        apply(0, 16'h1234, 8'd1, 0, 0, 0);    // R8 idle
        apply(0, 16'h0000, 8'd0, 0, 0, 1);    // R10 clear alone
        apply(0, 16'h0000, 8'd0, 0, 0, 0);    // R10 empty reads 0
        apply(2, 16'h7FFF, 8'd0, 0, 1, 0);    // R9 load 0
        apply(2, 16'h0003, 8'd0, 0, 1, 1);    // R10 clear with derive
        apply(3, 16'h0100, 8'd0, 0, 1, 0);    // R9 raise after restart

        for (int k = 0; k < 4000; k++) begin
            int op;
            logic [15:0] d;
            op = int'($urandom % 6);
            d  = 16'($urandom >> ($urandom % 24));
            if ($urandom % 2) d = ~d;
            apply(op, d, 8'($urandom), 1'($urandom), ($urandom % 8) != 0, ($urandom % 12) == 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule